// File: doc/BRIEF.md
# Phase-Shifted Energy-Balance Switching Controller

This block drives a stack of series half-bridge cells and the four-switch polarity bridge that follows them. Each cell has its own channel. At the start of its switching period a channel turns the cell's upper switch on. From zero, it then sums the product of the cell's DC voltage and the magnitude of the inductor current, one term per valid sample. When that running energy reaches a per-cycle energy target, the channel turns the upper switch off and the lower switch on. The channels share one period counter. Their start points are spread evenly across the period, so the cell outputs add up to a staircase.

The energy target has two parts. The first is |v_ref × i_out| multiplied by the number of samples in a period. It is refreshed on every valid sample. The second is the sum of |v_ind × i_ind| over a whole period, covering the energy stored in and returned by the inductor. A shared accumulator collects this sum. It is copied into a holding register at the start of channel 0's period and stays fixed for that period, so each period uses the sum from the period before. Dead time, in system clocks, separates every transition of a complementary pair. A channel that has not reached its target is forced off one clock before its next start. The bridge chooses its diagonal pair from the sign of v_ref.

Channel states: `CH_LOW` (lower on), `CH_RISE` (both off before the upper switch turns on), `CH_HIGH` (upper on, integrating) and `CH_FALL` (both off before the lower switch turns on). Channel transitions: *start* (`CH_LOW` or `CH_FALL` to `CH_RISE`), *rise-done* (`CH_RISE` to `CH_HIGH`), *trip* or *force* (`CH_HIGH` or `CH_RISE` to `CH_FALL`), and *fall-done* (`CH_FALL` to `CH_LOW`). Bridge states: `BR_GAP` (all four off), `BR_POS` and `BR_NEG`. Bridge transitions: *sign-flip* (`BR_POS` or `BR_NEG` to `BR_GAP`) and *gap-done* (`BR_GAP` to the pair selected by the latest sign).

Top module: `ebal_cascade_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, every `lower_g` bit is 1, every `upper_g` bit is 0 and `bridge_g` is 0000. After release, channel 0 starts on the first clock.
- R2: Channel k starts at count k·PERIOD/NCELL of a 0..PERIOD-1 counter. Its upper gate rises DEAD clocks after its start, so the upper-gate rises of channels 0 and 1 are PERIOD/NCELL clocks apart.
- R3: With constant inputs and `smp_vld` held high, the upper gate stays high for ceil(target / (cell_v × |i_ind|)) clocks, with a minimum of one. The integrator restarts from zero every period.
- R4: The first term of the target is |v_ref × i_out| × SPP. It uses the magnitude, so negative `v_ref` or negative `i_ind` gives the same widths as the positive values.
- R5: The second term is the sum of |v_ind × i_ind| over the previous full period. It is captured at channel 0's start and held through the period.
- R6: A channel that has not tripped is forced off one clock before its next start. The upper-gate width is therefore at most PERIOD−DEAD−1 clocks. After a forced off, the lower gate does not rise before the next start.
- R7: A cell's upper and lower gates are never both high. Each turn-on follows DEAD clocks with both gates low.
- R8: After a trip, the lower gate rises DEAD clocks after the upper gate falls and stays high until that channel's next start.
- R9: `bridge_g` bit0..bit3 drive switches 1..4. The pattern is 1001 when `v_ref` ≥ 0 and 0110 when `v_ref` < 0. On a sign change the bridge shows 0000 for DEAD clocks before the new pair turns on.
- R10: Samples with `smp_vld` low are ignored. With no valid samples the integrator never trips and the width is the forced limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe for all analog inputs |
| cell_v | input | NCELL·DW | Unsigned DC voltage per cell, cell k at bits k·DW |
| i_ind | input | DW | Signed inductor current |
| v_ind | input | DW | Signed inductor voltage |
| i_out | input | DW | Signed output current |
| v_ref | input | DW | Signed voltage reference |
| upper_g | output | NCELL | Upper switch gate per cell |
| lower_g | output | NCELL | Lower switch gate per cell |
| bridge_g | output | 4 | Polarity bridge gates, switches 1..4 |

## Verification
Two events can land on the same clock edge. Channel 0's start coincides with the capture of the held inductor-energy sum, because both happen at count 0. A comparator trip can also coincide with the forced-off edge. The first case is provoked by holding a nonzero inductor voltage until the widths settle; the bench then checks that channel 0 uses the full previous-period sum (width 12 instead of 4). The second case is provoked with a target of 1840 against a per-sample energy of 50. The trip then falls on the 37th integrating edge, which is also the force edge. The bench checks for a single clean turn-off: width 37, no overlap, and no rise of the lower gate inside the period.

// File: rtl/ebal_pkg.sv
package ebal_pkg;
    typedef enum logic [1:0] {CH_LOW, CH_RISE, CH_HIGH, CH_FALL} ch_st_e;
    typedef enum logic [1:0] {BR_GAP, BR_POS, BR_NEG} br_st_e;
endpackage

// File: rtl/ebal_phase_gen.sv
module ebal_phase_gen #(
    parameter int NCELL  = 2,
    parameter int PERIOD = 40
) (
    input  logic             clk,
    input  logic             rst,
    output logic [NCELL-1:0] start_o,
    output logic [NCELL-1:0] force_o
);
    localparam int CW = $clog2(PERIOD);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= (cnt_q == CW'(PERIOD-1)) ? '0 : cnt_q + 1'b1;
    end

    for (genvar k = 0; k < NCELL; k++) begin : g_ph
        localparam int OFS = k * PERIOD / NCELL;
        localparam int FPT = (OFS + PERIOD - 1) % PERIOD;
        assign start_o[k] = !rst && (cnt_q == CW'(OFS));
        assign force_o[k] = !rst && (cnt_q == CW'(FPT));

        // R6: the forced off is always followed by that channel's start
        a_r6_force_then_start: assert property (@(posedge clk) disable iff (rst)
            force_o[k] |=> start_o[k]);
    end

    // R2: the start points are distinct
    a_r2_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_o));
endmodule

// File: rtl/ebal_energy_ref.sv
module ebal_energy_ref #(
    parameter int DW  = 8,
    parameter int AW  = 24,
    parameter int SPP = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic                 cap_i,
    input  logic signed [DW-1:0] v_ref,
    input  logic signed [DW-1:0] i_out,
    input  logic signed [DW-1:0] v_ind,
    input  logic signed [DW-1:0] i_ind,
    output logic [AW:0]          ref_o
);
    localparam int PW = 2 * DW;
    logic signed [PW-1:0] p_out, p_ind;
    logic [PW-1:0]        m_out, m_ind;
    logic [AW-1:0]        t1_q, run_q, held_q;

    assign p_out = v_ref * i_out;
    assign p_ind = v_ind * i_ind;
    assign m_out = p_out[PW-1] ? PW'(-p_out) : PW'(p_out);
    assign m_ind = p_ind[PW-1] ? PW'(-p_ind) : PW'(p_ind);

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_q   <= '0;
            run_q  <= '0;
            held_q <= '0;
        end else begin
            if (vld_i) t1_q <= AW'(m_out) * AW'(SPP);
            if (cap_i) begin
                held_q <= run_q;
                run_q  <= vld_i ? AW'(m_ind) : '0;
            end else if (vld_i) begin
                run_q  <= run_q + AW'(m_ind);
            end
        end
    end

    assign ref_o = {1'b0, t1_q} + {1'b0, held_q};

    // R5: the inductor term only moves at a period capture
    a_r5_held_stable: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(held_q));
endmodule

// File: rtl/ebal_chan.sv
module ebal_chan
    import ebal_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 24,
    parameter int DEAD = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          force_i,
    input  logic          vld_i,
    input  logic [DW-1:0] cell_v,
    input  logic [DW-1:0] i_mag,
    input  logic [AW:0]   ref_i,
    output logic          hi_o,
    output logic          lo_o
);
    localparam int RW  = AW + 1;
    localparam int DCW = $clog2(DEAD + 1);
    ch_st_e          st_q, st_n;
    logic [DCW-1:0]  dcnt_q;
    logic [RW-1:0]   acc_q, acc_n;
    logic [2*DW-1:0] e_smp;
    logic            trip;

    assign e_smp = cell_v * i_mag;
    assign acc_n = acc_q + (vld_i ? RW'(e_smp) : '0);
    assign trip  = (acc_n >= ref_i);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            CH_LOW:  if (start_i) st_n = CH_RISE;
            CH_RISE: if (force_i) st_n = CH_FALL;
                     else if (dcnt_q == DCW'(DEAD-1)) st_n = CH_HIGH;
            CH_HIGH: if (force_i || trip) st_n = CH_FALL;
            CH_FALL: if (start_i) st_n = CH_RISE;
                     else if (dcnt_q == DCW'(DEAD-1)) st_n = CH_LOW;
            default: st_n = CH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CH_LOW;
            dcnt_q <= '0;
            acc_q  <= '0;
        end else begin
            st_q   <= st_n;
            dcnt_q <= (st_n != st_q) ? '0 : dcnt_q + 1'b1;
            acc_q  <= (st_q == CH_HIGH && st_n == CH_HIGH) ? acc_n : '0;
        end
    end

    always_comb begin
        hi_o = (st_q == CH_HIGH);
        lo_o = (st_q == CH_LOW);
    end

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hi_o && lo_o));
    a_r7_gap_after_upper: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_o) |-> !lo_o);
    a_r7_gap_after_lower: assert property (@(posedge clk) disable iff (rst)
        $fell(lo_o) |-> !hi_o);
    // R3: the integrator is zero whenever the upper switch has just opened
    a_r3_cleared_on_off: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_o) |-> (acc_q == '0));
    // R6: the upper switch is already open when a start arrives
    a_r6_off_at_start: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !hi_o);
endmodule

// File: rtl/ebal_bridge.sv
module ebal_bridge
    import ebal_pkg::*;
#(
    parameter int DEAD = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vld_i,
    input  logic       neg_i,
    output logic [3:0] gate_o
);
    localparam int DCW = $clog2(DEAD + 1);
    br_st_e         st_q, st_n;
    logic [DCW-1:0] dcnt_q;
    logic           tgt_neg_q;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            BR_GAP:  if (dcnt_q == DCW'(DEAD-1)) st_n = tgt_neg_q ? BR_NEG : BR_POS;
            BR_POS:  if (vld_i && neg_i)  st_n = BR_GAP;
            BR_NEG:  if (vld_i && !neg_i) st_n = BR_GAP;
            default: st_n = BR_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= BR_GAP;
            dcnt_q    <= '0;
            tgt_neg_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            dcnt_q <= (st_n != st_q) ? '0 : dcnt_q + 1'b1;
            if (vld_i) tgt_neg_q <= neg_i;
        end
    end

    always_comb begin
        unique case (st_q)
            BR_POS:  gate_o = 4'b1001;
            BR_NEG:  gate_o = 4'b0110;
            default: gate_o = 4'b0000;
        endcase
    end

    a_r9_legal_pattern: assert property (@(posedge clk) disable iff (rst)
        (gate_o == 4'b0000) || (gate_o == 4'b1001) || (gate_o == 4'b0110));
    a_r9_break_before_make: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_o) != 4'b0000 && gate_o != $past(gate_o)) |-> gate_o == 4'b0000);
endmodule

// File: rtl/ebal_cascade_ctrl.sv
module ebal_cascade_ctrl #(
    parameter int NCELL  = 2,
    parameter int PERIOD = 40,
    parameter int DEAD   = 2,
    parameter int DW     = 8,
    parameter int AW     = 24,
    parameter int SPP    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_vld,
    input  logic [NCELL*DW-1:0]   cell_v,
    input  logic signed [DW-1:0]  i_ind,
    input  logic signed [DW-1:0]  v_ind,
    input  logic signed [DW-1:0]  i_out,
    input  logic signed [DW-1:0]  v_ref,
    output logic [NCELL-1:0]      upper_g,
    output logic [NCELL-1:0]      lower_g,
    output logic [3:0]            bridge_g
);
    logic [NCELL-1:0] start_s, force_s;
    logic [AW:0]      ref_s;
    logic [DW-1:0]    i_mag;

    assign i_mag = i_ind[DW-1] ? DW'(-i_ind) : DW'(i_ind);

    ebal_phase_gen #(.NCELL(NCELL), .PERIOD(PERIOD)) u_phase (
        .clk(clk), .rst(rst), .start_o(start_s), .force_o(force_s));

    ebal_energy_ref #(.DW(DW), .AW(AW), .SPP(SPP)) u_ref (
        .clk(clk), .rst(rst), .vld_i(smp_vld), .cap_i(start_s[0]),
        .v_ref(v_ref), .i_out(i_out), .v_ind(v_ind), .i_ind(i_ind), .ref_o(ref_s));

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        ebal_chan #(.DW(DW), .AW(AW), .DEAD(DEAD)) u_chan (
            .clk(clk), .rst(rst), .start_i(start_s[k]), .force_i(force_s[k]),
            .vld_i(smp_vld), .cell_v(cell_v[k*DW +: DW]), .i_mag(i_mag),
            .ref_i(ref_s), .hi_o(upper_g[k]), .lo_o(lower_g[k]));
    end

    ebal_bridge #(.DEAD(DEAD)) u_bridge (
        .clk(clk), .rst(rst), .vld_i(smp_vld), .neg_i(v_ref[DW-1]), .gate_o(bridge_g));
endmodule

// File: tb/test_ebal_cascade_ctrl.sv
module test_ebal_cascade_ctrl;
    localparam int NCELL = 2, PERIOD = 40, DEAD = 2, DW = 8;
    localparam int WMAX = PERIOD - DEAD - 1;

    logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b1;
    logic [NCELL*DW-1:0] cell_v;
    logic signed [DW-1:0] i_ind, v_ind, i_out, v_ref;
    logic [NCELL-1:0] upper_g, lower_g;
    logic [3:0] bridge_g;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ebal_cascade_ctrl i_ebal_cascade_ctrl (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .cell_v(cell_v), .i_ind(i_ind),
        .v_ind(v_ind), .i_out(i_out), .v_ref(v_ref), .upper_g(upper_g),
        .lower_g(lower_g), .bridge_g(bridge_g));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_w(input int tgt, input int e);
        int w;
        if (e == 0) return WMAX;
        w = (tgt + e - 1) / e;
        if (w < 1) w = 1;
        return (w > WMAX) ? WMAX : w;
    endfunction

    // window anchored on the rise of channel 0's upper gate
    task automatic measure(output int w0, output int w1, output int r1,
                           output int l0, output int ov);
        logic pv1, pl0, prev;
        int guard = 0;
        w0 = 0; w1 = 0; r1 = -1; l0 = -1; ov = 0;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!prev && upper_g[0]) break;
            prev = upper_g[0];
            guard++;
            if (guard > 4 * PERIOD) begin
                chk("R2 channel 0 never started", 0, 1);
                return;
            end
        end
        pv1 = upper_g[1]; pl0 = lower_g[0];
        for (int k = 0; k < PERIOD + PERIOD / 2; k++) begin
            if (k > 0) @(negedge clk);
            if (k < PERIOD && upper_g[0]) w0++;
            if (k >= PERIOD / 2 && upper_g[1]) w1++;
            if (k > 0 && upper_g[1] && !pv1 && r1 < 0) r1 = k;
            if (k > 0 && k < PERIOD && lower_g[0] && !pl0 && l0 < 0) l0 = k;
            if ((upper_g & lower_g) != '0) ov++;
            pv1 = upper_g[1]; pl0 = lower_g[0];
        end
    endtask

    task automatic settle(output int w0, output int w1, output int r1,
                          output int l0, output int ov);
        for (int n = 0; n < 3; n++) measure(w0, w1, r1, l0, ov);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 lower gates in reset", int'(lower_g), 3);
        chk("R1 upper gates in reset", int'(upper_g), 0);
        chk("R1 bridge in reset", int'(bridge_g), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bridge off during first gap", int'(bridge_g), 0);
        repeat (DEAD + 1) @(negedge clk);
        chk("R9 positive pair after reset", int'(bridge_g), 4'b1001);
    endtask

    task automatic t_base;
        int w0, w1, r1, l0, ov;
        settle(w0, w1, r1, l0, ov);
        chk("R3 ch0 width", w0, exp_w(200, 50));
        chk("R3 ch1 width own cell voltage", w1, exp_w(200, 100));
        chk("R2 phase offset of ch1", r1, PERIOD / NCELL);
        chk("R8 lower rises after dead time", l0, exp_w(200, 50) + DEAD);
        chk("R7 no gate overlap", ov, 0);
    endtask

    task automatic t_neg;
        int w0, w1, r1, l0, ov;
        @(negedge clk);
        v_ref = -8'sd5; i_ind = -8'sd5;
        @(negedge clk); chk("R9 gap after sign flip", int'(bridge_g), 0);
        @(negedge clk); chk("R9 gap held", int'(bridge_g), 0);
        @(negedge clk); chk("R9 negative pair", int'(bridge_g), 4'b0110);
        settle(w0, w1, r1, l0, ov);
        chk("R4 magnitude with negative signs", w0, exp_w(200, 50));
        v_ref = 8'sd5; i_ind = 8'sd5;
        repeat (DEAD + 2) @(negedge clk);
        chk("R9 back to positive pair", int'(bridge_g), 4'b1001);
    endtask

    task automatic t_ind_energy;
        int w0, w1, r1, l0, ov;
        v_ind = 8'sd2;
        settle(w0, w1, r1, l0, ov);
        chk("R5 ch0 with inductor term", w0, exp_w(600, 50));
        chk("R5 ch1 with inductor term", w1, exp_w(600, 100));
        v_ind = -8'sd2;
        settle(w0, w1, r1, l0, ov);
        chk("R5 negative inductor voltage", w0, exp_w(600, 50));
        v_ind = 8'sd0;
        settle(w0, w1, r1, l0, ov);
        chk("R5 term removed next periods", w0, exp_w(200, 50));
    endtask

    task automatic t_limit;
        int w0, w1, r1, l0, ov;
        v_ref = 8'sd20; i_out = 8'sd23;
        settle(w0, w1, r1, l0, ov);
        chk("R6 trip on force edge width", w0, WMAX);
        chk("R6 lower stays off after forced end", l0, -1);
        chk("R7 no overlap at coincidence", ov, 0);
        v_ref = 8'sd50; i_out = 8'sd50;
        settle(w0, w1, r1, l0, ov);
        chk("R6 forced width cap", w0, WMAX);
        v_ref = 8'sd5; i_out = 8'sd10;
    endtask

    task automatic t_novld;
        int w0, w1, r1, l0, ov;
        @(negedge clk); smp_vld = 1'b0;
        settle(w0, w1, r1, l0, ov);
        chk("R10 no valid samples width", w0, WMAX);
        chk("R10 ch1 no valid samples", w1, WMAX);
        smp_vld = 1'b1;
        settle(w0, w1, r1, l0, ov);
        chk("R3 recovers after samples resume", w0, exp_w(200, 50));
    endtask

    task automatic t_midreset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run lower gates", int'(lower_g), 3);
        chk("R1 mid-run upper gates", int'(upper_g), 0);
        rst = 1'b0;
    endtask

    initial begin
        cell_v = {8'd20, 8'd10};
        i_ind = 8'sd5; v_ind = 8'sd0; i_out = 8'sd10; v_ref = 8'sd5;
        t_reset();
        t_base();
        t_neg();
        t_ind_energy();
        t_limit();
        t_novld();
        t_midreset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule